// File: doc/BRIEF.md
# Fractal Frame Pixel Scanner and Packed Frame Writer

This block drives the rendering of one escape-time fractal frame. On a start pulse it walks every pixel of an H_PIX by V_PIX raster in row-major order. It gives each pixel a point of the complex plane by stepping linearly across a programmable rectangle. It deals those points out to a pool of external iteration units, which may take very different numbers of cycles per pixel. Each unit that reports itself idle is handed the next pixel, so a unit stuck in a slow region never holds up the others.

Each finished unit returns an 8-bit colour tagged with its pixel index. The block accepts one result per cycle. It pairs horizontally adjacent pixels, in whatever order they come back, and writes each pair as one 16-bit word into an external frame memory.

The region is set by the left real edge and the top imaginary edge of the display, plus precomputed per-pixel steps. The lower-left and upper-right corners follow from these, and the caller picks the steps to set the aspect ratio. A frame cycle counter reports the render time and holds it until the next frame is started.

Top module: `mandel_frame_scanner`

## Requirements
- R1: After reset, busy, done, mem_we and all disp_valid bits are 0 and frame_cycles is 0, even when units report idle.
- R2: Coordinates use 36-bit two's complement with 33 fractional bits. Out of reset the region is the default one: left edge −2, top edge +1, step_re = floor(3·2^33/H_PIX), step_im = floor(2·2^33/V_PIX). Pixel (col,row) is issued with disp_re = left + col·step_re and disp_im = top − row·step_im, both taken modulo 2^36.
- R3: A region_load pulse while not busy captures load_re_min, load_im_max, load_step_re and load_step_im, and all later frames map pixels with these values as in R2. A region_load pulse while busy has no effect.
- R4: After a start, each pixel is dispatched exactly once, in raster order, with disp_index = row·H_PIX + col.
- R5: At most one unit is granted per cycle, and only a unit whose unit_idle bit is high. The granted unit is the first idle one at or after the unit following the last one granted, wrapping around. Unit 0 comes first after reset.
- R6: At most one result is accepted per cycle, and only from a unit with res_valid high. The choice is round-robin in the same way as R5, and results are accepted only while busy.
- R7: A word is written once both of its pixels have been accepted, in either order. The word address is disp_index/2, the even column goes in mem_wdata[7:0] and the odd column in [15:8], and each word is written exactly once per frame.
- R8: mem_we is high exactly in the cycle after the cycle in which the second pixel of a word is accepted.
- R9: When the last of the H_PIX·V_PIX/2 words has been written, busy falls and done rises, and done stays high until the next start.
- R10: frame_cycles is cleared by start and then counts every cycle in which busy is high. It keeps its value while idle until the next start.
- R11: A start pulse while busy is ignored: the frame in progress is neither restarted nor repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a full frame recompute |
| region_load | input | 1 | Capture a new region |
| load_re_min | input | 36 | Real coordinate of the left edge |
| load_im_max | input | 36 | Imaginary coordinate of the top line |
| load_step_re | input | 36 | Real step per column |
| load_step_im | input | 36 | Imaginary step per line |
| unit_idle | input | N_UNITS | Unit can take a pixel |
| disp_valid | output | N_UNITS | One-hot grant of the current pixel |
| disp_re | output | 36 | Real part of the dispatched point |
| disp_im | output | 36 | Imaginary part of the dispatched point |
| disp_index | output | log2(H·V) | Index of the dispatched pixel |
| res_valid | input | N_UNITS | Unit holds a finished result |
| res_index | input | N_UNITS·log2(H·V) | Pixel index per unit |
| res_color | input | N_UNITS·8 | Colour per unit |
| res_accept | output | N_UNITS | One-hot acceptance of a result |
| mem_we | output | 1 | Frame memory write strobe |
| mem_addr | output | log2(H·V)−1 | Word address |
| mem_wdata | output | 16 | Two packed pixels |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Last frame complete |
| frame_cycles | output | 32 | Cycles spent on the last or current frame |

## Verification
The bench models the iteration units with per-pixel latencies that make results return out of order. This means odd pixels often finish before their even partners, and a design that paired by arrival order or assumed the even half comes first would pack the wrong bytes or write a word twice. One run takes a unit out of the pool and makes another very slow. A dispatcher that granted a unit that was not idle, or that did not rotate, would show up as a pixel handed to the wrong unit or a stalled frame. Start and region-load pulses arrive in the middle of a frame: a design that obeyed them would repeat pixels, reset the cycle count or change coordinates partway through. Coordinates are compared at every dispatch against the product form of the mapping, which catches a missed row wrap or an off-by-one step.

// File: rtl/mfs_pkg.sv
// Shared fixed-point definitions for the frame scanner.
// Assumes coordinates in signed 3.33 format (36 bits, 33 fraction bits).
package mfs_pkg;
    localparam int FX_W    = 36;
    localparam int FX_FRAC = 33;
    typedef logic [FX_W-1:0] fx_t;
endpackage

// File: rtl/mfs_rr_arb.sv
// Round-robin arbiter: grants the first requester at or after the unit
// following the last grant. Assumes req may change every cycle; the pointer
// moves only when a grant is given.
module mfs_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    logic [PW-1:0] win;
    logic          hit;

    // Pick the first requester searching upward from the pointer.
    always_comb begin
        int k;
        gnt = '0;
        win = ptr;
        hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            k = (int'(ptr) + i) % N;
            if (!hit && req[k]) begin
                hit    = 1'b1;
                gnt[k] = 1'b1;
                win    = PW'(k);
            end
        end
    end

    // Advance the pointer past the unit just served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (hit) begin
            ptr <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
        end
    end

    // R5 and R6: a grant is one-hot and only to a requester.
    p_gnt_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));
endmodule

// File: rtl/mfs_coord_scan.sv
// Raster scanner: holds the next pixel to hand out and its complex point.
// Assumes the region inputs are stable for the whole frame; the point is
// formed by repeated addition of the per-pixel steps, never by division.
module mfs_coord_scan
    import mfs_pkg::*;
#(
    parameter int H_PIX = 640,
    parameter int V_PIX = 480,
    parameter int IW    = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_frame,
    input  fx_t           re_min,
    input  fx_t           im_max,
    input  fx_t           step_re,
    input  fx_t           step_im,
    input  logic          adv,
    output logic          valid,
    output fx_t           re,
    output fx_t           im,
    output logic [IW-1:0] index
);
    localparam int CW = (H_PIX > 1) ? $clog2(H_PIX) : 1;
    localparam int RW = (V_PIX > 1) ? $clog2(V_PIX) : 1;

    logic [CW-1:0] col;
    logic [RW-1:0] row;

    // Step column, row and point each time the current pixel is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            col   <= '0;
            row   <= '0;
            re    <= '0;
            im    <= '0;
            index <= '0;
        end else if (start_frame) begin
            valid <= 1'b1;
            col   <= '0;
            row   <= '0;
            re    <= re_min;
            im    <= im_max;
            index <= '0;
        end else if (adv) begin
            index <= index + 1'b1;
            if (col == CW'(H_PIX - 1)) begin
                col <= '0;
                re  <= re_min;
                im  <= im - step_im;
                if (row == RW'(V_PIX - 1)) begin
                    valid <= 1'b0;
                end else begin
                    row <= row + 1'b1;
                end
            end else begin
                col <= col + 1'b1;
                re  <= re + step_re;
            end
        end
    end

    // R4: a pixel is only taken while one remains.
    p_adv_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> valid);
    // R4: the column never leaves the raster.
    p_col_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(col) < H_PIX && int'(row) < V_PIX));
endmodule

// File: rtl/mfs_pair_pack.sv
// Pair packer: holds the first-arriving half of each word in a small
// associative buffer and writes the word when its partner arrives.
// Assumes one result per cycle, and that at most N_SLOT words are half-done
// at once (units in flight plus one).
module mfs_pair_pack #(
    parameter int N_SLOT = 5,
    parameter int IW     = 19,
    parameter int COL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [IW-1:0]      in_index,
    input  logic [COL_W-1:0]   in_color,
    output logic               mem_we,
    output logic [IW-2:0]      mem_addr,
    output logic [2*COL_W-1:0] mem_wdata
);
    localparam int AW = IW - 1;
    localparam int SW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

    logic [N_SLOT-1:0] s_vld;
    logic [AW-1:0]     s_addr [N_SLOT];
    logic [COL_W-1:0]  s_col  [N_SLOT];

    logic [AW-1:0] in_addr;
    logic          hit;
    logic [SW-1:0] hit_k;
    logic          free_ok;
    logic [SW-1:0] free_k;

    assign in_addr = in_index[IW-1:1];

    // Look up the partner half and the first free slot.
    always_comb begin
        hit     = 1'b0;
        hit_k   = '0;
        free_ok = 1'b0;
        free_k  = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            if (!hit && s_vld[s] && s_addr[s] == in_addr) begin
                hit   = 1'b1;
                hit_k = SW'(s);
            end
            if (!free_ok && !s_vld[s]) begin
                free_ok = 1'b1;
                free_k  = SW'(s);
            end
        end
    end

    // Park a lone half, or complete and write a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (in_valid) begin
                if (hit) begin
                    s_vld[hit_k] <= 1'b0;
                    mem_we       <= 1'b1;
                    mem_addr     <= in_addr;
                    mem_wdata    <= in_index[0] ? {in_color, s_col[hit_k]}
                                                : {s_col[hit_k], in_color};
                end else if (free_ok) begin
                    s_vld[free_k]  <= 1'b1;
                    s_addr[free_k] <= in_addr;
                    s_col[free_k]  <= in_color;
                end
            end
        end
    end

    // R7: a lone half always finds room.
    p_slot_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !hit) |-> free_ok);
    // R8: every write is the consequence of a result in the cycle before.
    p_we_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(in_valid));
endmodule

// File: rtl/mandel_frame_scanner.sv
// Top: holds the region, runs the frame, deals pixels to idle iteration
// units, gathers results into packed words and times the frame.
// Assumes each unit drops unit_idle the cycle after it is granted and holds
// res_valid until res_accept; the frame memory takes one write every cycle.
module mandel_frame_scanner
    import mfs_pkg::*;
#(
    parameter int H_PIX   = 640,
    parameter int V_PIX   = 480,
    parameter int N_UNITS = 4,
    parameter int COL_W   = 8,
    parameter int CYC_W   = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      start,
    input  logic                                      region_load,
    input  logic [FX_W-1:0]                           load_re_min,
    input  logic [FX_W-1:0]                           load_im_max,
    input  logic [FX_W-1:0]                           load_step_re,
    input  logic [FX_W-1:0]                           load_step_im,
    input  logic [N_UNITS-1:0]                        unit_idle,
    output logic [N_UNITS-1:0]                        disp_valid,
    output logic [FX_W-1:0]                           disp_re,
    output logic [FX_W-1:0]                           disp_im,
    output logic [$clog2(H_PIX*V_PIX)-1:0]            disp_index,
    input  logic [N_UNITS-1:0]                        res_valid,
    input  logic [N_UNITS*$clog2(H_PIX*V_PIX)-1:0]    res_index,
    input  logic [N_UNITS*COL_W-1:0]                  res_color,
    output logic [N_UNITS-1:0]                        res_accept,
    output logic                                      mem_we,
    output logic [$clog2(H_PIX*V_PIX)-2:0]            mem_addr,
    output logic [2*COL_W-1:0]                        mem_wdata,
    output logic                                      busy,
    output logic                                      done,
    output logic [CYC_W-1:0]                          frame_cycles
);
    localparam int  TOTAL   = H_PIX * V_PIX;
    localparam int  IW      = $clog2(TOTAL);
    localparam int  AW      = IW - 1;
    localparam int  N_WORDS = TOTAL / 2;
    localparam int  N_SLOT  = N_UNITS + 1;
    localparam fx_t DEF_RE  = FX_W'(64'd0 - (64'd2 << FX_FRAC));
    localparam fx_t DEF_IM  = FX_W'(64'd1 << FX_FRAC);
    localparam fx_t DEF_DX  = FX_W'((64'd3 << FX_FRAC) / 64'(H_PIX));
    localparam fx_t DEF_DY  = FX_W'((64'd2 << FX_FRAC) / 64'(V_PIX));

    fx_t rg_re_min, rg_im_max, rg_step_re, rg_step_im;
    logic           start_go;
    logic           scan_valid;
    logic [AW:0]    word_cnt;
    logic           last_word;
    logic           sel_valid;
    logic [IW-1:0]  sel_index;
    logic [COL_W-1:0] sel_color;

    assign start_go  = start && !busy;
    assign last_word = mem_we && (word_cnt == (AW+1)'(N_WORDS - 1));

    // Region registers: default plane at reset, reloaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_re_min  <= DEF_RE;
            rg_im_max  <= DEF_IM;
            rg_step_re <= DEF_DX;
            rg_step_im <= DEF_DY;
        end else if (region_load && !busy) begin
            rg_re_min  <= load_re_min;
            rg_im_max  <= load_im_max;
            rg_step_re <= load_step_re;
            rg_step_im <= load_step_im;
        end
    end

    // Frame control: busy from start to last word, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            word_cnt <= '0;
        end else if (start_go) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            word_cnt <= '0;
        end else if (busy && mem_we) begin
            word_cnt <= word_cnt + 1'b1;
            if (last_word) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // Frame timer: cleared on start, counts busy cycles, holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cycles <= '0;
        end else if (start_go) begin
            frame_cycles <= '0;
        end else if (busy) begin
            frame_cycles <= frame_cycles + 1'b1;
        end
    end

    mfs_coord_scan #(
        .H_PIX (H_PIX),
        .V_PIX (V_PIX),
        .IW    (IW)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_frame (start_go),
        .re_min      (rg_re_min),
        .im_max      (rg_im_max),
        .step_re     (rg_step_re),
        .step_im     (rg_step_im),
        .adv         (|disp_valid),
        .valid       (scan_valid),
        .re          (disp_re),
        .im          (disp_im),
        .index       (disp_index)
    );

    mfs_rr_arb #(.N(N_UNITS)) u_disp_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (unit_idle & {N_UNITS{scan_valid}}),
        .gnt   (disp_valid)
    );

    mfs_rr_arb #(.N(N_UNITS)) u_res_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (res_valid & {N_UNITS{busy}}),
        .gnt   (res_accept)
    );

    // Route the accepted unit's index and colour to the packer.
    always_comb begin
        sel_valid = |res_accept;
        sel_index = '0;
        sel_color = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (res_accept[u]) begin
                sel_index = sel_index | res_index[u*IW +: IW];
                sel_color = sel_color | res_color[u*COL_W +: COL_W];
            end
        end
    end

    mfs_pair_pack #(
        .N_SLOT (N_SLOT),
        .IW     (IW),
        .COL_W  (COL_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (sel_valid),
        .in_index  (sel_index),
        .in_color  (sel_color),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R5: pixels go only to idle units.
    p_idle_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid & ~unit_idle) == '0);
    // R6: results are taken only from units that hold one.
    p_accept_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_accept & ~res_valid) == '0);
    // R9: writes happen only inside a frame.
    p_we_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
    // R9: a finished frame is quiet.
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (disp_valid == '0 && !mem_we && !busy));
    // R10: the timer holds between frames.
    p_cycles_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(frame_cycles));
    // R11: a frame only ends on its last word.
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |=> busy);
    // R3: the region stays fixed during a frame.
    p_region_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rg_re_min) && $stable(rg_step_im));
endmodule

// File: tb/mandel_frame_scanner_tb.sv
// Directed bench: a small raster, modelled iteration units with chosen
// latencies, and a monitor that checks every dispatch, accept and write.
module mandel_frame_scanner_tb;
    localparam int TH   = 8;
    localparam int TV   = 4;
    localparam int TN   = 3;
    localparam int TOT  = TH * TV;
    localparam int WRDS = TOT / 2;
    localparam int IW   = $clog2(TOT);
    localparam int AW   = IW - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic region_load = 1'b0;
    logic [35:0] load_re_min = '0, load_im_max = '0, load_step_re = '0, load_step_im = '0;
    logic [TN-1:0] unit_idle;
    logic [TN-1:0] disp_valid;
    logic [35:0] disp_re, disp_im;
    logic [IW-1:0] disp_index;
    logic [TN-1:0] res_valid;
    logic [TN*IW-1:0] res_index;
    logic [TN*8-1:0] res_color;
    logic [TN-1:0] res_accept;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic busy, done;
    logic [31:0] frame_cycles;

    always #4 clk = ~clk;

    mandel_frame_scanner #(
        .H_PIX(TH), .V_PIX(TV), .N_UNITS(TN), .COL_W(8), .CYC_W(32)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .region_load(region_load),
        .load_re_min(load_re_min), .load_im_max(load_im_max),
        .load_step_re(load_step_re), .load_step_im(load_step_im),
        .unit_idle(unit_idle), .disp_valid(disp_valid), .disp_re(disp_re),
        .disp_im(disp_im), .disp_index(disp_index), .res_valid(res_valid),
        .res_index(res_index), .res_color(res_color), .res_accept(res_accept),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .frame_cycles(frame_cycles)
    );

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    // Expected region and frame bookkeeping.
    logic [35:0] ex_re0, ex_im0, ex_dx, ex_dy;
    string coord_tag = "R2";
    bit mon_on = 0;
    int lat_mode = 0;
    int salt = 0;
    int n_disp = 0;
    int busy_cnt = 0;
    int disp_ptr = 0;
    int acc_ptr = 0;
    bit half [WRDS];
    int wcount [WRDS];
    logic [15:0] mem_img [WRDS];
    bit wr_pend = 0;
    int wr_addr = 0;

    // Unit model state.
    logic [TN-1:0] free;
    logic [TN-1:0] en_mask = '1;
    bit got_disp [TN];
    bit got_acc [TN];
    int new_lat [TN];
    int new_idx [TN];
    int cnt [TN];
    int job [TN];

    assign unit_idle = free & en_mask;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] colf(input int i);
        return 8'(i * 37 + 11 + salt * 29);
    endfunction

    function automatic int latf(input int i, input int u);
        case (lat_mode)
            0: return 0;
            1: return (i * 5 + u * 3) % 7;
            default: return (u == 0) ? 20 : i % 3;
        endcase
    endfunction

    function automatic int first_from(input logic [TN-1:0] v, input int p);
        for (int i = 0; i < TN; i++) begin
            if (v[(p + i) % TN]) return (p + i) % TN;
        end
        return -1;
    endfunction

    // Monitor: samples mid-cycle and checks dispatch, accept and writes.
    always @(negedge clk) begin
        for (int u = 0; u < TN; u++) begin
            got_disp[u] = 0;
            got_acc[u] = 0;
        end
        if (rst_n && mon_on) begin
            if (busy) busy_cnt++;
            if (mem_we || wr_pend) begin
                chk(mem_we == wr_pend, "R8", "write strobe", mem_we, wr_pend);
                if (mem_we && wr_pend) begin
                    chk(int'(mem_addr) == wr_addr, "R7", "word address", mem_addr, wr_addr);
                    chk(mem_wdata == {colf(2*wr_addr+1), colf(2*wr_addr)}, "R7",
                        "packed data", mem_wdata, {colf(2*wr_addr+1), colf(2*wr_addr)});
                end
                if (mem_we) begin
                    wcount[mem_addr]++;
                    mem_img[mem_addr] = mem_wdata;
                end
            end
            wr_pend = 0;
            if (busy && n_disp < TOT && (|unit_idle)) begin
                int eu;
                eu = first_from(unit_idle, disp_ptr);
                chk(disp_valid == TN'(1 << eu), "R5", "dispatch grant", disp_valid, 1 << eu);
            end else if (disp_valid != '0) begin
                chk(0, "R5", "unexpected grant", disp_valid, 0);
            end
            if ($onehot(disp_valid)) begin
                int u, col, row;
                logic [35:0] er, ei;
                u = $clog2(disp_valid);
                col = n_disp % TH;
                row = n_disp / TH;
                er = ex_re0 + 36'(col) * ex_dx;
                ei = ex_im0 - 36'(row) * ex_dy;
                chk(int'(disp_index) == n_disp, "R4", "pixel index", disp_index, n_disp);
                chk(disp_re == er, coord_tag, "real coordinate", disp_re, er);
                chk(disp_im == ei, coord_tag, "imag coordinate", disp_im, ei);
                got_disp[u] = 1;
                new_idx[u] = int'(disp_index);
                new_lat[u] = latf(n_disp, u);
                n_disp++;
                disp_ptr = (u + 1) % TN;
            end
            if (busy && (|res_valid)) begin
                int eu;
                eu = first_from(res_valid, acc_ptr);
                chk(res_accept == TN'(1 << eu), "R6", "result accept", res_accept, 1 << eu);
                if (res_accept == TN'(1 << eu)) begin
                    int ri;
                    ri = int'(res_index[eu*IW +: IW]);
                    got_acc[eu] = 1;
                    acc_ptr = (eu + 1) % TN;
                    if (half[ri/2]) begin
                        wr_pend = 1;
                        wr_addr = ri / 2;
                    end else begin
                        half[ri/2] = 1;
                    end
                end
            end else if (res_accept != '0) begin
                chk(0, "R6", "unexpected accept", res_accept, 0);
            end
        end
    end

    // Unit model: registered behaviour driven by what the monitor saw.
    always @(posedge clk) begin
        if (!rst_n) begin
            free <= '1;
            res_valid <= '0;
            res_index <= '0;
            res_color <= '0;
        end else begin
            for (int u = 0; u < TN; u++) begin
                if (got_disp[u]) begin
                    free[u] <= 1'b0;
                    cnt[u] <= new_lat[u];
                    job[u] <= new_idx[u];
                end else if (!free[u] && !res_valid[u]) begin
                    if (cnt[u] == 0) begin
                        res_valid[u] <= 1'b1;
                        res_index[u*IW +: IW] <= IW'(job[u]);
                        res_color[u*8 +: 8] <= colf(job[u]);
                    end else begin
                        cnt[u] <= cnt[u] - 1;
                    end
                end else if (res_valid[u] && got_acc[u]) begin
                    res_valid[u] <= 1'b0;
                    free[u] <= 1'b1;
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [35:0] fx(input real r);
        return 36'(longint'(r * 8589934592.0));
    endfunction

    task automatic frame_prep(input int mode, input int s);
        lat_mode = mode;
        salt = s;
        n_disp = 0;
        busy_cnt = 0;
        for (int w = 0; w < WRDS; w++) begin
            half[w] = 0;
            wcount[w] = 0;
        end
        mon_on = 1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic frame_finish(input string tag);
        int guard, bad;
        logic [31:0] held;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(done && !busy, "R9", {tag, " done after frame"}, {done, busy}, 2);
        chk(n_disp == TOT, "R4", {tag, " pixels dispatched"}, n_disp, TOT);
        bad = 0;
        for (int w = 0; w < WRDS; w++) begin
            if (wcount[w] != 1 || mem_img[w] != {colf(2*w+1), colf(2*w)}) bad++;
        end
        chk(bad == 0, "R7", {tag, " words wrong or not written once"}, bad, 0);
        chk(frame_cycles == 32'(busy_cnt), "R10", {tag, " frame cycles"}, frame_cycles, busy_cnt);
        held = frame_cycles;
        repeat (6) @(negedge clk);
        chk(frame_cycles == held && done, "R10", {tag, " timer holds"}, frame_cycles, held);
        mon_on = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset", {busy, done}, 0);
        chk(disp_valid == '0 && unit_idle != '0, "R1", "no dispatch", disp_valid, 0);
        chk(!mem_we, "R1", "no write", mem_we, 0);
        chk(frame_cycles == 0, "R1", "timer clear", frame_cycles, 0);
    endtask

    task automatic t_default_frame();
        ex_re0 = fx(-2.0);
        ex_im0 = fx(1.0);
        ex_dx = 36'((64'd3 << 33) / TH);
        ex_dy = 36'((64'd2 << 33) / TV);
        coord_tag = "R2";
        en_mask = '1;
        frame_prep(0, 1);
        frame_finish("default");
    endtask

    task automatic t_zoom_frame();
        @(negedge clk);
        load_re_min = fx(-0.758);
        load_im_max = fx(0.06);
        load_step_re = fx(0.008 / TH);
        load_step_im = fx(0.01 / TV);
        region_load = 1'b1;
        @(negedge clk);
        region_load = 1'b0;
        ex_re0 = load_re_min;
        ex_im0 = load_im_max;
        ex_dx = load_step_re;
        ex_dy = load_step_im;
        coord_tag = "R3";
        frame_prep(1, 2);
        frame_finish("zoom");
    endtask

    task automatic t_busy_ignores();
        frame_prep(1, 3);
        repeat (5) @(negedge clk);
        load_re_min = fx(0.5);
        load_step_re = fx(0.25);
        region_load = 1'b1;
        start = 1'b1;
        @(negedge clk);
        region_load = 1'b0;
        start = 1'b0;
        chk(busy, "R11", "still busy after start pulse", busy, 1);
        frame_finish("restart ignored");
    endtask

    task automatic t_slow_unit();
        en_mask = 3'b101;
        frame_prep(2, 4);
        frame_finish("slow unit");
        en_mask = '1;
    endtask

    initial begin
        t_reset();
        t_default_frame();
        t_zoom_frame();
        t_busy_ignores();
        t_slow_unit();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule